// File: doc/BRIEF.md
# Rotated Immediate Codec

This block converts between a full 32-bit constant and a compact 12-bit immediate field. The field packs an 8-bit base value and a 4-bit rotation count. The constant it stands for is the base, zero-extended to 32 bits and rotated right by twice the count. A rotation is not a shift: bits that leave the low end come back in at the high end.

The decode path takes a field and registers the expanded constant, so the result appears one clock later. The encode path takes a constant on a start pulse and tries the rotation counts from zero upwards, one count per clock. It stops at the first count that works, so the result is the canonical encoding with the smallest rotation. If no count works, it reports that the constant cannot be encoded. A core's instruction decoder can use the decode path, and an assembler-style constant checker can use the encode path.

Top module: `rimm_codec`

## Requirements
- R1: `dec_value` equals the base in `dec_field[7:0]`, zero-extended and rotated right by 2 × `dec_field[11:8]`. It appears one clock edge after the field is sampled.
- R2: The decode rotation wraps. Field 0x808 gives 0x00080000, field 0x1F3 gives 0xC000003C, and field 0x4FF gives 0xFF000000.
- R3: A rotation count of 0 passes the base through unchanged in bits [7:0], with bits [31:8] zero.
- R4: On success, `enc_field` holds the encoding with the smallest rotation count that decodes back to the constant. For 0x00080000 this is 0x702. A nonzero count therefore never comes with base bits [1:0] both zero.
- R5: When the canonical count is k, `enc_done` is high with `enc_valid` high at the k+1-th clock edge after the edge that accepted `enc_start`.
- R6: A constant with no encoding gives `enc_done` with `enc_valid` low and `enc_field` zero, at the 16th edge after acceptance.
- R7: An `enc_start` that arrives while `enc_busy` is high is ignored. The search in progress finishes with its own constant and its own timing.
- R8: `enc_busy` is high from the accepting edge until the edge that raises `enc_done`. `enc_done` lasts one cycle.
- R9: While reset is held, `enc_busy`, `enc_done` and `enc_valid` are low, and `enc_field` and `dec_value` are zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| dec_field | input | 12 | Field to expand: count in [11:8], base in [7:0] |
| dec_value | output | 32 | Expanded constant, registered |
| enc_start | input | 1 | Starts a search when the block is idle |
| enc_value | input | 32 | Constant to encode, sampled with `enc_start` |
| enc_busy | output | 1 | Search in progress |
| enc_done | output | 1 | One-cycle pulse when the search ends |
| enc_valid | output | 1 | Result of the last search was encodable |
| enc_field | output | 12 | Canonical field of the last successful search |

## Verification
A fault in the rotation-count register shows up as a wrong `enc_field`, or as `enc_done` arriving at the wrong edge. The bench times every search, so a count that starts at the wrong value or skips a value changes the completion cycle right away. A count that does not stop at 15 stretches the failure case past 16 edges. Wrong latch control on the target register shows up in the ignored-start case as a result built from the second constant. Decode faults appear on the very next cycle, because every one of the 4096 fields is checked.

// File: rtl/rimm_pkg.sv
package rimm_pkg;

    localparam int DATA_W  = 32;
    localparam int BASE_W  = 8;
    localparam int ROT_W   = 4;
    localparam int FIELD_W = BASE_W + ROT_W;
    localparam int STEPS   = 1 << ROT_W;

    typedef logic [DATA_W-1:0] word_t;

    typedef struct packed {
        logic [ROT_W-1:0]  rot;
        logic [BASE_W-1:0] base;
    } field_t;

    typedef enum logic {
        SCAN_IDLE = 1'b0,
        SCAN_RUN  = 1'b1
    } scan_state_e;

    function automatic word_t ror_w(word_t x, int unsigned amt);
        logic [2*DATA_W-1:0] d;
        d = {x, x} >> (amt % DATA_W);
        return d[DATA_W-1:0];
    endfunction

    function automatic word_t rol_w(word_t x, int unsigned amt);
        logic [2*DATA_W-1:0] d;
        d = {x, x} << (amt % DATA_W);
        return d[2*DATA_W-1:DATA_W];
    endfunction

    function automatic word_t expand_field(field_t f);
        word_t b;
        b = word_t'(f.base);
        return ror_w(b, 2 * int'(f.rot));
    endfunction

endpackage

// File: rtl/rimm_expand.sv
module rimm_expand
    import rimm_pkg::*;
(
    input  logic               clk,
    input  logic               rst,
    input  logic [FIELD_W-1:0] field_in,
    output word_t              value_out
);
    field_t f;
    word_t  expanded;

    always_comb begin
        f        = field_t'(field_in);
        expanded = expand_field(f);
    end

    always_ff @(posedge clk) begin
        if (rst) value_out <= '0;
        else     value_out <= expanded;
    end
endmodule

// File: rtl/rimm_probe.sv
module rimm_probe
    import rimm_pkg::*;
(
    input  word_t             target,
    input  logic [ROT_W-1:0]  count,
    output logic              hit,
    output logic [BASE_W-1:0] base
);
    word_t undone;

    always_comb begin
        undone = rol_w(target, 2 * int'(count));
        hit    = (undone[DATA_W-1:BASE_W] == '0);
        base   = undone[BASE_W-1:0];
    end
endmodule

// File: rtl/rimm_search.sv
module rimm_search
    import rimm_pkg::*;
(
    input  logic               clk,
    input  logic               rst,
    input  logic               start,
    input  word_t              value,
    output logic               busy,
    output logic               done,
    output logic               valid,
    output logic [FIELD_W-1:0] field_out
);
    localparam logic [ROT_W-1:0] LAST = ROT_W'(STEPS - 1);

    scan_state_e       state;
    word_t             target;
    logic [ROT_W-1:0]  count;
    logic              hit;
    logic [BASE_W-1:0] base;
    field_t            result;

    rimm_probe u_probe (
        .target (target),
        .count  (count),
        .hit    (hit),
        .base   (base)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            state  <= SCAN_IDLE;
            target <= '0;
            count  <= '0;
            done   <= 1'b0;
            valid  <= 1'b0;
            result <= '0;
        end else begin
            done <= 1'b0;
            case (state)
                SCAN_IDLE: begin
                    if (start) begin
                        target <= value;
                        count  <= '0;
                        state  <= SCAN_RUN;
                    end
                end
                SCAN_RUN: begin
                    if (hit) begin
                        state       <= SCAN_IDLE;
                        done        <= 1'b1;
                        valid       <= 1'b1;
                        result.rot  <= count;
                        result.base <= base;
                    end else if (count == LAST) begin
                        state  <= SCAN_IDLE;
                        done   <= 1'b1;
                        valid  <= 1'b0;
                        result <= '0;
                    end else begin
                        count <= count + 1'b1;
                    end
                end
                default: state <= SCAN_IDLE;
            endcase
        end
    end

    assign busy      = (state == SCAN_RUN);
    assign field_out = result;
endmodule

// File: rtl/rimm_codec.sv
module rimm_codec
    import rimm_pkg::*;
(
    input  logic                  clk,
    input  logic                  rst,
    input  logic [FIELD_W-1:0]    dec_field,
    output logic [DATA_W-1:0]     dec_value,
    input  logic                  enc_start,
    input  logic [DATA_W-1:0]     enc_value,
    output logic                  enc_busy,
    output logic                  enc_done,
    output logic                  enc_valid,
    output logic [FIELD_W-1:0]    enc_field
);
    rimm_expand u_expand (
        .clk       (clk),
        .rst       (rst),
        .field_in  (dec_field),
        .value_out (dec_value)
    );

    rimm_search u_search (
        .clk       (clk),
        .rst       (rst),
        .start     (enc_start),
        .value     (enc_value),
        .busy      (enc_busy),
        .done      (enc_done),
        .valid     (enc_valid),
        .field_out (enc_field)
    );
endmodule

// File: rtl/rimm_codec_chk.sv
module rimm_codec_chk
    import rimm_pkg::*;
(
    input logic               clk,
    input logic               rst,
    input logic [FIELD_W-1:0] dec_field,
    input logic [DATA_W-1:0]  dec_value,
    input logic               enc_start,
    input logic [DATA_W-1:0]  enc_value,
    input logic               enc_busy,
    input logic               enc_done,
    input logic               enc_valid,
    input logic [FIELD_W-1:0] enc_field
);
    logic   seen;
    word_t  tgt;
    logic [ROT_W+1:0] busy_len;
    field_t ef;

    assign ef = field_t'(enc_field);

    always_ff @(posedge clk) begin
        if (rst) begin
            seen     <= 1'b0;
            tgt      <= '0;
            busy_len <= '0;
        end else begin
            seen <= 1'b1;
            if (!enc_busy && enc_start) tgt <= enc_value;
            if (enc_busy) busy_len <= busy_len + 1'b1;
            else          busy_len <= '0;
        end
    end

    AST_DEC_EXPAND: assert property (@(posedge clk) disable iff (rst)
        seen |-> dec_value == expand_field(field_t'($past(dec_field)))); // R1

    AST_CANON_FORM: assert property (@(posedge clk) disable iff (rst)
        (enc_done && enc_valid && ef.rot != '0) |-> ef.base[1:0] != 2'b00); // R4

    AST_ROUND_TRIP: assert property (@(posedge clk) disable iff (rst)
        (enc_done && enc_valid) |-> expand_field(ef) == tgt); // R4

    AST_HIT_LATENCY: assert property (@(posedge clk) disable iff (rst)
        (enc_done && enc_valid) |-> busy_len == (ROT_W+2)'(ef.rot) + 1'b1); // R5

    AST_MISS_LATENCY: assert property (@(posedge clk) disable iff (rst)
        (enc_done && !enc_valid) |-> busy_len == (ROT_W+2)'(STEPS) && enc_field == '0); // R6

    AST_BUSY_HOLDS: assert property (@(posedge clk) disable iff (rst)
        enc_busy |=> (enc_busy || enc_done)); // R7

    AST_DONE_PULSE: assert property (@(posedge clk) disable iff (rst)
        enc_done |=> !enc_done); // R8

    AST_BUSY_ENDS: assert property (@(posedge clk) disable iff (rst)
        $fell(enc_busy) |-> enc_done); // R8

    AST_DONE_IDLE: assert property (@(posedge clk) disable iff (rst)
        enc_done |-> !enc_busy); // R8
endmodule

bind rimm_codec rimm_codec_chk u_chk (
    .clk       (clk),
    .rst       (rst),
    .dec_field (dec_field),
    .dec_value (dec_value),
    .enc_start (enc_start),
    .enc_value (enc_value),
    .enc_busy  (enc_busy),
    .enc_done  (enc_done),
    .enc_valid (enc_valid),
    .enc_field (enc_field)
);

// File: tb/tb_rimm_codec.sv
module tb_rimm_codec;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [11:0] dec_field = '0;
    logic [31:0] dec_value;
    logic        enc_start = 1'b0;
    logic [31:0] enc_value = '0;
    logic        enc_busy, enc_done, enc_valid;
    logic [11:0] enc_field;

    int checks = 0;
    int fails  = 0;
    bit finished = 0;

    always #2.5 clk = ~clk;

    rimm_codec dut (
        .clk(clk), .rst(rst), .dec_field(dec_field), .dec_value(dec_value),
        .enc_start(enc_start), .enc_value(enc_value), .enc_busy(enc_busy),
        .enc_done(enc_done), .enc_valid(enc_valid), .enc_field(enc_field)
    );

    function automatic logic [31:0] rotr(logic [31:0] x, int a);
        if (a == 0) return x;
        return (x >> a) | (x << (32 - a));
    endfunction

    function automatic logic [31:0] ref_decode(logic [11:0] f);
        return rotr({24'h0, f[7:0]}, 2 * int'(f[11:8]));
    endfunction

    task automatic check(bit ok, string req, logic [31:0] act, logic [31:0] exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    // brute force over the fields in ascending order: the first match has the smallest count
    task automatic ref_encode(logic [31:0] v, output bit ok, output logic [11:0] f);
        ok = 0; f = '0;
        for (int i = 0; i < 4096; i++) begin
            if (!ok && ref_decode(12'(i)) == v) begin
                ok = 1; f = 12'(i);
            end
        end
    endtask

    task automatic run_encode(logic [31:0] v, bit poke);
        bit          eok;
        logic [11:0] ef;
        int          cyc;
        ref_encode(v, eok, ef);
        @(negedge clk);
        enc_start = 1'b1; enc_value = v;
        @(posedge clk);
        @(negedge clk);
        enc_start = 1'b0;
        check(enc_busy === 1'b1, "R8 busy after accept", 32'(enc_busy), 32'd1);
        cyc = 0;
        while (!enc_done && cyc < 40) begin
            if (poke && cyc == 3) begin
                enc_start = 1'b1; enc_value = 32'h0000_0001;  // R7 start while busy
            end
            @(posedge clk);
            @(negedge clk);
            enc_start = 1'b0;
            cyc++;
        end
        check(enc_valid === eok, eok ? "R5 valid" : "R6 valid low",
              32'(enc_valid), 32'(eok));
        check(enc_busy === 1'b0, "R8 busy ends at done", 32'(enc_busy), 32'd0);
        if (eok) begin
            check(enc_field === ef, poke ? "R7 field" : "R4 canonical field",
                  32'(enc_field), 32'(ef));
            check(cyc == int'(ef[11:8]) + 1, "R5 latency", 32'(cyc), 32'(ef[11:8]) + 1);
        end else begin
            check(enc_field === 12'h000, "R6 field zero", 32'(enc_field), 32'h0);
            check(cyc == 16, poke ? "R7 latency kept" : "R6 latency", 32'(cyc), 32'd16);
        end
        @(posedge clk);
        @(negedge clk);
        check(enc_done === 1'b0, "R8 done pulse", 32'(enc_done), 32'd0);
    endtask

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        check(enc_busy === 1'b0,  "R9 busy",  32'(enc_busy),  32'd0);
        check(enc_done === 1'b0,  "R9 done",  32'(enc_done),  32'd0);
        check(enc_valid === 1'b0, "R9 valid", 32'(enc_valid), 32'd0);
        check(enc_field === 12'h0, "R9 field", 32'(enc_field), 32'd0);
        check(dec_value === 32'h0, "R9 dec", dec_value, 32'd0);
        rst = 1'b0;

        // R1 exhaustive decode sweep
        for (int i = 0; i < 4096; i++) begin
            dec_field = 12'(i);
            @(posedge clk);
            @(negedge clk);
            check(dec_value === ref_decode(12'(i)), "R1 decode", dec_value, ref_decode(12'(i)));
            if (i < 256)
                check(dec_value === {24'h0, 8'(i)}, "R3 count zero", dec_value, {24'h0, 8'(i)});
        end
        // R2 wrap cases
        dec_field = 12'h808; @(posedge clk); @(negedge clk);
        check(dec_value === 32'h0008_0000, "R2 0x808", dec_value, 32'h0008_0000);
        dec_field = 12'h1F3; @(posedge clk); @(negedge clk);
        check(dec_value === 32'hC000_003C, "R2 0x1F3", dec_value, 32'hC000_003C);
        dec_field = 12'h4FF; @(posedge clk); @(negedge clk);
        check(dec_value === 32'hFF00_0000, "R2 0x4FF", dec_value, 32'hFF00_0000);

        // R4 named case, then sweep
        run_encode(32'h0008_0000, 0);
        check(enc_field === 12'h702, "R4 0x80000 -> 0x702", 32'(enc_field), 32'h702);
        run_encode(32'h0, 0);
        for (int r = 0; r < 16; r++)
            for (int b = 1; b < 256; b += 9)
                run_encode(rotr({24'h0, 8'(b)}, 2 * r), 0);
        // R6 non-encodable constants
        run_encode(32'h0000_0101, 0);
        run_encode(32'h0000_01FE, 0);
        run_encode(32'hFFFF_FFFF, 0);
        run_encode(32'h1234_5678, 0);
        // R7 start while busy
        run_encode(32'h0000_0101, 1);
        run_encode(32'h0003_FC00, 1);

        finished = 1;
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

    initial begin
        repeat (190000) @(posedge clk);
        if (!finished) begin
            checks++; fails++;
            $display("FAIL watchdog actual=%h expected=%h", 32'd0, 32'd1);
            $display("%0d/%0d checks passed", checks - fails, checks);
            $finish;
        end
    end
endmodule